// File: doc/BRIEF.md
# Block-Tiled Surface Start Address Calculator

This block turns the description of a three-dimensional block-tiled surface, plus the element at which a transfer begins, into the words that a transfer engine needs before it can walk the surface. It splits the byte position along x, the row y and the slice z into an in-tile part and a tile index on each axis. It combines them into a byte offset and adds that offset to a 40-bit base address. It also produces a tile-row control word, a pitch word, a word that holds the upper address byte and the size of a Y/Z tile, and a flag that marks the wide x-tile layout.

A request is made by pulsing `start` for one cycle with all inputs valid. The block captures the inputs on that edge and runs a fixed five-state sequence, so the multipliers each get a cycle of their own. It then pulses `done` and holds every result until the next accepted request. Any `start` that arrives while a request is in flight is dropped.

Top module: `tiled_addr_calc`

## Requirements
- R1: If `tile_mode[3:0]` equals 4'hE, the x tile shift Tp is 4 and `wide_tile` is 0. For any other code, Tp is 6 and `wide_tile` is 1.
- R2: The y tile shift Th is `tile_mode[7:4]` plus the parameter TH_BIAS (default 2). The z tile shift Td is `tile_mode[11:8]`.
- R3: The block forms the 40-bit sum `base_addr` + offset. `addr_low` is bits 31:0 of the sum, and a carry out of bit 31 reaches the upper address byte.
- R4: Let xb = x_off·cpp. Then offset = (xb mod 2^Tp) + ((y mod 2^Th) << Tp) + ((z mod 2^Td) << (Tp+Th)) + (((z>>Td)·nTy·nTx + (y>>Th)·nTx + (xb>>Tp)) << (Tp+Th+Td)), where nTx = ceil(width·cpp / 2^Tp) and nTy = ceil(height / 2^Th). All of this is computed modulo 2^32.
- R5: `ytile_word` = (2^Th << 12) | (2^Th − (y mod 2^Th)), computed modulo 2^32.
- R6: `pitch_word` = (nTx − 1) << (Tp+Th+Td), computed modulo 2^32. A zero width wraps nTx − 1 to all ones before the shift.
- R7: `addr_high_word` = (sum bits 39:32 << 16) | ((2^Th >> 2) << Td).
- R8: `done` is high for exactly one cycle. It rises on the fifth rising edge, counting the edge that accepted `start` as the first.
- R9: A `start` seen while a request is in flight is ignored. It produces no extra `done` and does not change the results.
- R10: Between `done` pulses, all result outputs hold their values.
- R11: A synchronous active-high reset clears `done` and all result outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted only when the block is idle |
| base_addr | input | ADDR_W (40) | Surface base byte address |
| tile_mode | input | 12 | Tile shape: [3:0] x code, [7:4] y shift less bias, [11:8] z shift |
| surf_width | input | X_W (19) | Surface width in elements |
| surf_height | input | Y_W (13) | Surface height in rows |
| x_off | input | X_W (19) | Start element along x |
| y_off | input | Y_W (13) | Start row |
| z_off | input | Z_W (12) | Start slice |
| cpp | input | CPP_W (5) | Bytes per element |
| done | output | 1 | One-cycle result strobe |
| addr_low | output | 32 | Low 32 bits of the start address |
| addr_high_word | output | 32 | Upper address byte at bits 23:16, OR-ed with the Y/Z tile size |
| ytile_word | output | 32 | Tile-row height and the rows left in the first tile |
| pitch_word | output | 32 | Byte distance between tile rows |
| wide_tile | output | 1 | Wide x-tile layout in use |

## Verification
Every result of a request becomes valid together, on the edge that raises `done`. That edge is the fifth rising edge counting the accepting edge. The driver sets `start` at a falling edge and checks `done` on the following falling edges: low on the first four and high on the fifth. The monitor compares the outputs only at that fifth falling edge, against an entry the driver queued. Holding and ignored-start behaviour is checked a few falling edges after the pulse, when the outputs must still equal the last expected entry and no second `done` may have appeared.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    localparam int WORD_W    = 32;
    localparam int MODE_W    = 12;
    localparam int SH_W      = 6;
    localparam int TP_NARROW = 4;
    localparam int TP_WIDE   = 6;
    localparam int YT_SHIFT  = 12;
    localparam int HI_SHIFT  = 16;
    localparam logic [3:0] NARROW_CODE = 4'hE;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SH_W-1:0]   shamt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL1,
        ST_SPLIT,
        ST_MUL2,
        ST_FIN
    } state_e;

    typedef struct packed {
        shamt_t tp;
        shamt_t th;
        shamt_t td;
        logic   wide;
    } shifts_t;

    typedef struct packed {
        word_t txo;
        word_t tx;
        word_t tyo;
        word_t ty;
        word_t tzo;
        word_t tz;
        word_t ntx;
        word_t nty;
    } split_t;

    function automatic word_t pow2(input shamt_t s);
        return word_t'(1) << s;
    endfunction

    function automatic word_t low_part(input word_t v, input shamt_t s);
        return v & (pow2(s) - word_t'(1));
    endfunction

    function automatic word_t ceil_shr(input word_t v, input shamt_t s);
        return (v + pow2(s) - word_t'(1)) >> s;
    endfunction

endpackage

// File: rtl/tsa_mode_decode.sv
module tsa_mode_decode
    import tsa_pkg::*;
#(
    parameter int TH_BIAS = 2
) (
    input  logic [MODE_W-1:0] mode,
    output shifts_t           sh
);

    logic is_wide;

    always_comb begin
        is_wide = (mode[3:0] != NARROW_CODE);
        sh.wide = is_wide;
        sh.tp   = is_wide ? shamt_t'(TP_WIDE) : shamt_t'(TP_NARROW);
        sh.th   = shamt_t'(mode[7:4]) + shamt_t'(TH_BIAS);
        sh.td   = shamt_t'(mode[11:8]);
    end

endmodule

// File: rtl/tsa_split.sv
module tsa_split
    import tsa_pkg::*;
(
    input  word_t   xb,
    input  word_t   wb,
    input  word_t   y_w,
    input  word_t   z_w,
    input  word_t   h_w,
    input  shifts_t sh,
    output split_t  sp
);

    always_comb begin
        sp.txo = low_part(xb, sh.tp);
        sp.tx  = xb >> sh.tp;
        sp.tyo = low_part(y_w, sh.th);
        sp.ty  = y_w >> sh.th;
        sp.tzo = low_part(z_w, sh.td);
        sp.tz  = z_w >> sh.td;
        sp.ntx = ceil_shr(wb, sh.tp);
        sp.nty = ceil_shr(h_w, sh.th);
    end

endmodule

// File: rtl/tsa_ctrl.sv
module tsa_ctrl
    import tsa_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output state_e state,
    output logic   accept,
    output logic   done
);

    assign accept = start && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            done <= (state == ST_FIN);
            unique case (state)
                ST_IDLE:  if (start) state <= ST_MUL1;
                ST_MUL1:  state <= ST_SPLIT;
                ST_SPLIT: state <= ST_MUL2;
                ST_MUL2:  state <= ST_FIN;
                ST_FIN:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tiled_addr_calc.sv
module tiled_addr_calc
    import tsa_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int X_W     = 19,
    parameter int Y_W     = 13,
    parameter int Z_W     = 12,
    parameter int CPP_W   = 5,
    parameter int TH_BIAS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [MODE_W-1:0] tile_mode,
    input  logic [X_W-1:0]    surf_width,
    input  logic [Y_W-1:0]    surf_height,
    input  logic [X_W-1:0]    x_off,
    input  logic [Y_W-1:0]    y_off,
    input  logic [Z_W-1:0]    z_off,
    input  logic [CPP_W-1:0]  cpp,
    output logic              done,
    output logic [WORD_W-1:0] addr_low,
    output logic [WORD_W-1:0] addr_high_word,
    output logic [WORD_W-1:0] ytile_word,
    output logic [WORD_W-1:0] pitch_word,
    output logic              wide_tile
);

    localparam int HI_W = ADDR_W - WORD_W;

    state_e  state;
    logic    accept;
    shifts_t sh_dec, sh_q;
    split_t  sp_d, sp_q;

    logic [ADDR_W-1:0] base_q;
    word_t w_q, h_q, x_q, y_q, z_q, c_q;
    word_t xb_q, wb_q, idx_q;

    tsa_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .state  (state),
        .accept (accept),
        .done   (done)
    );

    tsa_mode_decode #(.TH_BIAS(TH_BIAS)) u_dec (
        .mode (tile_mode),
        .sh   (sh_dec)
    );

    tsa_split u_split (
        .xb  (xb_q),
        .wb  (wb_q),
        .y_w (y_q),
        .z_w (z_q),
        .h_w (h_q),
        .sh  (sh_q),
        .sp  (sp_d)
    );

    // Final combination, used only in ST_FIN
    shamt_t            ts_xy, ts_all;
    word_t             offset, th_pow;
    logic [ADDR_W-1:0] full_sum;
    logic [HI_W-1:0]   hi_part;

    always_comb begin
        ts_xy    = sh_q.tp + sh_q.th;
        ts_all   = ts_xy + sh_q.td;
        th_pow   = pow2(sh_q.th);
        offset   = sp_q.txo
                 + (sp_q.tyo << sh_q.tp)
                 + (sp_q.tzo << ts_xy)
                 + (idx_q << ts_all);
        full_sum = base_q + ADDR_W'(offset);
        hi_part  = full_sum[ADDR_W-1:WORD_W];
    end

    // Operand capture and pipeline registers
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            sh_q   <= '0;
            w_q    <= '0;
            h_q    <= '0;
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            c_q    <= '0;
            xb_q   <= '0;
            wb_q   <= '0;
            sp_q   <= '0;
            idx_q  <= '0;
        end else begin
            if (accept) begin
                base_q <= base_addr;
                sh_q   <= sh_dec;
                w_q    <= word_t'(surf_width);
                h_q    <= word_t'(surf_height);
                x_q    <= word_t'(x_off);
                y_q    <= word_t'(y_off);
                z_q    <= word_t'(z_off);
                c_q    <= word_t'(cpp);
            end
            if (state == ST_MUL1) begin
                xb_q <= x_q * c_q;
                wb_q <= w_q * c_q;
            end
            if (state == ST_SPLIT) begin
                sp_q <= sp_d;
            end
            if (state == ST_MUL2) begin
                idx_q <= sp_q.tz * sp_q.nty * sp_q.ntx
                       + sp_q.ty * sp_q.ntx
                       + sp_q.tx;
            end
        end
    end

    // Result registers, loaded once per request
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_low       <= '0;
            addr_high_word <= '0;
            ytile_word     <= '0;
            pitch_word     <= '0;
            wide_tile      <= 1'b0;
        end else if (state == ST_FIN) begin
            addr_low       <= full_sum[WORD_W-1:0];
            addr_high_word <= (word_t'(hi_part) << HI_SHIFT)
                            | ((th_pow >> 2) << sh_q.td);
            ytile_word     <= (th_pow << YT_SHIFT) | (th_pow - sp_q.tyo);
            pitch_word     <= (sp_q.ntx - word_t'(1)) << ts_all;
            wide_tile      <= sh_q.wide;
        end
    end

endmodule

// File: rtl/tsa_checker.sv
module tsa_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        done,
    input logic [31:0] addr_low,
    input logic [31:0] addr_high_word,
    input logic [31:0] ytile_word,
    input logic [31:0] pitch_word,
    input logic        wide_tile
);

    // R8
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 5));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(addr_low) && $stable(addr_high_word) &&
                   $stable(ytile_word) && $stable(pitch_word) &&
                   $stable(wide_tile)));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!done && addr_low == '0 && addr_high_word == '0 &&
                 ytile_word == '0 && pitch_word == '0 && !wide_tile));

endmodule

bind tiled_addr_calc tsa_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .done           (done),
    .addr_low       (addr_low),
    .addr_high_word (addr_high_word),
    .ytile_word     (ytile_word),
    .pitch_word     (pitch_word),
    .wide_tile      (wide_tile)
);

// File: tb/tiled_addr_calc_tb.sv
module tiled_addr_calc_tb;

    localparam int TH_BIAS = 2;

    typedef struct {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] yt;
        logic [31:0] pt;
        logic        wide;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [39:0] base_addr = '0;
    logic [11:0] tile_mode = '0;
    logic [18:0] surf_width = '0;
    logic [12:0] surf_height = '0;
    logic [18:0] x_off = '0;
    logic [12:0] y_off = '0;
    logic [11:0] z_off = '0;
    logic [4:0]  cpp = '0;
    logic        done;
    logic [31:0] addr_low, addr_high_word, ytile_word, pitch_word;
    logic        wide_tile;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t q[$];
    exp_t last_exp;

    always #5 clk = ~clk;

    tiled_addr_calc #(.TH_BIAS(TH_BIAS)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .base_addr      (base_addr),
        .tile_mode      (tile_mode),
        .surf_width     (surf_width),
        .surf_height    (surf_height),
        .x_off          (x_off),
        .y_off          (y_off),
        .z_off          (z_off),
        .cpp            (cpp),
        .done           (done),
        .addr_low       (addr_low),
        .addr_high_word (addr_high_word),
        .ytile_word     (ytile_word),
        .pitch_word     (pitch_word),
        .wide_tile      (wide_tile)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [39:0] b, input logic [11:0] m,
                                   input logic [31:0] w, input logic [31:0] h,
                                   input logic [31:0] x, input logic [31:0] y,
                                   input logic [31:0] z, input logic [31:0] c);
        exp_t e;
        int unsigned tp = (m[3:0] == 4'hE) ? 4 : 6;          // R1
        int unsigned th = int'(m[7:4]) + TH_BIAS;            // R2
        int unsigned td = int'(m[11:8]);                     // R2
        logic [31:0] xb = x * c;
        logic [31:0] wb = w * c;
        logic [31:0] ptp = 32'd1 << tp;
        logic [31:0] pth = 32'd1 << th;
        logic [31:0] ptd = 32'd1 << td;
        logic [31:0] ntx = (wb + ptp - 1) >> tp;
        logic [31:0] nty = (h + pth - 1) >> th;
        logic [31:0] tyo = y & (pth - 1);
        logic [31:0] idx = (z >> td) * nty * ntx + (y >> th) * ntx + (xb >> tp);
        logic [31:0] off = (xb & (ptp - 1)) + (tyo << tp)
                         + ((z & (ptd - 1)) << (tp + th)) + (idx << (tp + th + td));
        logic [39:0] sum = b + {8'h00, off};
        e.lo   = sum[31:0];
        e.hi   = {8'h00, sum[39:32], 16'h0000} | ((pth >> 2) << td);
        e.yt   = (pth << 12) | (pth - tyo);
        e.pt   = (ntx - 1) << (tp + th + td);
        e.wide = (m[3:0] != 4'hE);
        return e;
    endfunction

    task automatic compare_out(input exp_t e, input string when);
        chk({"R3 R4 addr_low ", when}, addr_low, e.lo);
        chk({"R7 addr_high_word ", when}, addr_high_word, e.hi);
        chk({"R5 R2 ytile_word ", when}, ytile_word, e.yt);
        chk({"R6 pitch_word ", when}, pitch_word, e.pt);
        chk({"R1 wide_tile ", when}, {31'd0, wide_tile}, {31'd0, e.wide});
    endtask

    // Monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R9 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                compare_out(e, "at done");
            end
        end
    end

    // Driver: one request, optionally with a second start while busy
    task automatic run(input logic [39:0] b, input logic [11:0] m,
                       input logic [18:0] w, input logic [12:0] h,
                       input logic [18:0] x, input logic [12:0] y,
                       input logic [11:0] z, input logic [4:0] c,
                       input bit extra_start);
        exp_t e;
        e = model(b, m, 32'(w), 32'(h), 32'(x), 32'(y), 32'(z), 32'(c));
        q.push_back(e);
        last_exp = e;
        base_addr = b; tile_mode = m; surf_width = w; surf_height = h;
        x_off = x; y_off = y; z_off = z; cpp = c;
        start = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 1 && extra_start) begin
                // R9: different operands, start still high while busy
                base_addr = b ^ 40'hFF_0000_0000;
                x_off = x + 19'd3;
                tile_mode = m ^ 12'h00F;
            end else begin
                start = 1'b0;
            end
            if (k == 2) start = 1'b0;
            if (k < 5) chk("R8 done low before fifth edge", {31'd0, done}, 32'd0);
            else       chk("R8 done high on fifth edge", {31'd0, done}, 32'd1);
        end
        repeat (3) @(negedge clk);
        chk("R8 R9 no further done", {31'd0, done}, 32'd0);
        compare_out(last_exp, "R10 hold");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset done", {31'd0, done}, 32'd0);
        chk("R11 reset addr_low", addr_low, 32'd0);
        chk("R11 reset addr_high_word", addr_high_word, 32'd0);
        chk("R11 reset ytile_word", ytile_word, 32'd0);
        chk("R11 reset pitch_word", pitch_word, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 narrow tile, R4 basic offset
        run(40'h12_0000_1000, 12'h00E, 19'd100, 13'd64, 19'd5, 13'd3, 12'd0, 5'd4, 0);
        // R1 wide tile, R2 biased Th, z tiling
        run(40'h00_4000_0000, 12'h213, 19'd300, 13'd50, 19'd37, 13'd21, 12'd9, 5'd2, 0);
        // R3 carry into the high byte
        run(40'h05_FFFF_FFF0, 12'h10E, 19'd64, 13'd16, 19'd20, 13'd5, 12'd3, 5'd1, 0);
        // R6 zero width wraps nTx - 1
        run(40'h00_0000_0000, 12'h000, 19'd0, 13'd8, 19'd0, 13'd0, 12'd0, 5'd1, 0);
        // R5 origin start, larger Th
        run(40'h7A_1234_5678, 12'h35E, 19'd1000, 13'd500, 19'd0, 13'd0, 12'd0, 5'd8, 0);
        // R9 start while busy is ignored
        run(40'h01_0000_0100, 12'h121, 19'd77, 13'd33, 19'd11, 13'd9, 12'd5, 5'd3, 1);

        begin
            logic [31:0] s = 32'h1357_9BDF;
            for (int i = 0; i < 8; i++) begin
                logic [39:0] b;
                logic [11:0] m;
                s = s * 32'd1103515245 + 32'd12345;
                b = {s[7:0], s ^ 32'hA5A5_5A5A};
                m = s[27:16];
                s = s * 32'd1103515245 + 32'd12345;
                run(b, m, s[18:0], s[31:19], s[30:12], s[12:0], s[23:12],
                    5'd1 + {1'b0, s[3:0]}, (i % 3) == 0);
            end
        end

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule